// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block counts overflow pulses coming from an upstream interval timer in a 6-bit counter. It compares the count with a match value that software writes. One enable bit decides what a match does. With the bit set, the block works as a watchdog: a match produces a single-cycle chip reset request. With the bit clear, a match sets a sticky interrupt flag and sends the counter back to zero, so the block becomes a periodic interval timer. In that mode the period is the match value times the upstream timer's period.

Software talks to the block through a small register port with two registers. The compare register holds the match value and a counter-clear command. A watchdog service routine writes it with the clear bit set before the count reaches the match value. The control register holds the enable bit and the write-one-to-clear interrupt flag. While a stop-mode input is high the counter is frozen, and it resumes by itself once stop is released.

Top module: `wdtIntervalTimer`

## Requirements
- R1: After the asynchronous active-low reset, the counter is 0, the enable bit is 0, the compare register reads 0x3F, and both resetReq and irqFlag are low.
- R2: The counter advances by exactly one for each cycle in which tick is high and stopMode is low, and wraps from 63 to 0. While stopMode is high, ticks are ignored and the count holds.
- R3: With regSel=0 the port addresses the compare register. A write loads bits [5:0] as the match value. Bit 6 written as 1 zeroes the counter at the next clock edge. A read returns the match value in bits [5:0] and 0 in bits 7 and 6.
- R4: With regSel=1 the port addresses the control register. Bit 5 is the enable bit and reads back as written. A read returns irqFlag in bit 7 and 0 in every other bit except bit 5.
- R5: With the enable bit at 1, the tick that brings the count to the match value causes resetReq to be high for exactly one cycle, two clock edges after that tick is sampled. irqFlag is left unchanged, and the counter keeps counting.
- R6: With the enable bit at 0, the tick that brings the count to the match value sets irqFlag two edges later, and the counter returns to 0 on that same edge. Interrupts therefore repeat every M ticks for a match value M from 1 to 63, and every 64 ticks for M = 0. No reset request is produced.
- R7: irqFlag stays set until a control-register write with bit 7 at 1. A write with bit 7 at 0 leaves it set. A clear that lands on the same edge as a new set leaves the flag set.
- R8: A counter-clear write takes priority over a tick in the same cycle. The tick is discarded, and a full match interval is needed after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 compare, 1 control |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| tick | input | 1 | Overflow pulse from the upstream interval timer |
| stopMode | input | 1 | Stop mode: freezes the counter while high |
| resetReq | output | 1 | Single-cycle chip reset request (watchdog mode) |
| irqFlag | output | 1 | Sticky interval interrupt flag (timer mode) |

## Verification
The bench builds the block with its default parameters: a 6-bit counter in an 8-bit register port. At that size every match value from 0 to 63 fits in one sweep. In timer mode the bench runs each value for two back-to-back periods, and compares the number of ticks to each interrupt with the match value, or with 64 for zero. In watchdog mode a spread of match values, including the wrap value 0, is measured the same way against the count of reset pulses. Because the counter is so narrow, the corner cases of simultaneous events can be hit on exact cycles: clear against tick, flag clear against flag set, and stop against tick.

// File: rtl/wdtPkg.sv
package wdtPkg;

  // Strobes the control half hands to the datapath each cycle
  typedef struct packed {
    logic loadCmp;   // capture a new match value
    logic clearCnt;  // software counter clear (highest priority)
    logic advance;   // accepted tick
    logic wrapCnt;   // timer-mode return to zero after a match
  } ctrlStrobes_t;

  // Register select encoding
  localparam logic SEL_CMP  = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int CNT_W = 6,
  parameter logic [CNT_W-1:0] CMP_RESET = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] cmpData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             hitNext
);

  logic [CNT_W-1:0] baseVal;
  logic [CNT_W-1:0] incVal;

  // After a timer-mode match the count restarts from zero, and a tick
  // arriving on that very cycle is still counted on top of the zero.
  always_comb begin
    baseVal = strobes.wrapCnt ? '0 : countVal;
    incVal  = baseVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.clearCnt) begin
      countVal <= '0;
    end else if (strobes.advance) begin
      countVal <= incVal;
    end else if (strobes.wrapCnt) begin
      countVal <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= CMP_RESET;
    end else if (strobes.loadCmp) begin
      cmpVal <= cmpData;
    end
  end

  // A match counts only when a tick carries the counter onto the value
  always_comb begin
    hitNext = strobes.advance && !strobes.clearCnt && (incVal == cmpVal);
  end

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         wrClrBit,
  input  logic         wrEnBit,
  input  logic         wrIrqBit,
  input  logic         tick,
  input  logic         stopMode,
  input  logic         hitNext,
  output ctrlStrobes_t strobes,
  output logic         wdEnable,
  output logic         resetReq,
  output logic         irqFlag
);

  logic wrCmp;
  logic wrCtrl;
  logic hitQ;
  logic irqSet;
  logic irqClr;

  always_comb begin
    wrCmp            = regWrEn && (regSel == SEL_CMP);
    wrCtrl           = regWrEn && (regSel == SEL_CTRL);
    strobes.loadCmp  = wrCmp;
    strobes.clearCnt = wrCmp && wrClrBit;
    strobes.advance  = tick && !stopMode;
    strobes.wrapCnt  = hitQ && !wdEnable;
    irqSet           = hitQ && !wdEnable;
    irqClr           = wrCtrl && wrIrqBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdEnable <= 1'b0;
      hitQ     <= 1'b0;
      resetReq <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        wdEnable <= wrEnBit;
      end
      hitQ     <= hitNext;
      resetReq <= hitQ && wdEnable;
      // set beats clear on a shared edge
      if (irqSet) begin
        irqFlag <= 1'b1;
      end else if (irqClr) begin
        irqFlag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdtIntervalTimer.sv
module wdtIntervalTimer
  import wdtPkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8,
  parameter int EN_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tick,
  input  logic              stopMode,
  output logic              resetReq,
  output logic              irqFlag
);

  localparam int CLR_BIT = CNT_W;
  localparam int IRQ_BIT = DATA_W - 1;

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] cmpVal;
  logic             hitNext;
  logic             wdEnable;

  wdtControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .wrClrBit (regWrData[CLR_BIT]),
    .wrEnBit  (regWrData[EN_BIT]),
    .wrIrqBit (regWrData[IRQ_BIT]),
    .tick     (tick),
    .stopMode (stopMode),
    .hitNext  (hitNext),
    .strobes  (strobes),
    .wdEnable (wdEnable),
    .resetReq (resetReq),
    .irqFlag  (irqFlag)
  );

  wdtDatapath #(.CNT_W(CNT_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmpData  (regWrData[CNT_W-1:0]),
    .countVal (countVal),
    .cmpVal   (cmpVal),
    .hitNext  (hitNext)
  );

  always_comb begin
    regRdData = '0;
    if (regSel == SEL_CTRL) begin
      regRdData[EN_BIT]  = wdEnable;
      regRdData[IRQ_BIT] = irqFlag;
    end else begin
      regRdData[CNT_W-1:0] = cmpVal;
    end
  end

endmodule

// File: rtl/wdtChecker.sv
module wdtChecker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regSel,
  input logic [7:0]       regWrData,
  input logic             stopMode,
  input logic             resetReq,
  input logic             irqFlag,
  input logic             wdEnable,
  input logic [CNT_W-1:0] countVal
);

  // R5
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R5
  reset_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(wdEnable));

  // R6
  irq_needs_timer_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !$past(wdEnable));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !(regWrEn && regSel && regWrData[7])) |=> irqFlag);

  // R3
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && regWrData[CNT_W]) |=> (countVal == '0));

  // R2
  stop_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && $past(stopMode) && !(regWrEn && !regSel && regWrData[CNT_W]))
      |=> $stable(countVal));

endmodule

bind wdtIntervalTimer wdtChecker #(.CNT_W(CNT_W)) i_wdtChecker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData[7:0]),
  .stopMode  (stopMode),
  .resetReq  (resetReq),
  .irqFlag   (irqFlag),
  .wdEnable  (wdEnable),
  .countVal  (countVal)
);

// File: tb/test_wdtIntervalTimer.sv
module test_wdtIntervalTimer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       tick = 1'b0;
  logic       stopMode = 1'b0;
  logic       resetReq;
  logic       irqFlag;

  int total = 0;
  int bad = 0;
  int rstRises = 0;
  int rstHigh = 0;
  int cycles = 0;
  logic rstPrev = 1'b0;

  always #5 clk = ~clk;

  wdtIntervalTimer i_wdtIntervalTimer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .tick(tick),
    .stopMode(stopMode), .resetReq(resetReq), .irqFlag(irqFlag)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (resetReq) rstHigh <= rstHigh + 1;
    if (resetReq && !rstPrev) rstRises <= rstRises + 1;
    rstPrev <= resetReq;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
    regSel = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int n;
    int base;
    int pulsesBefore;
    int highBefore;
    int mList[7] = '{1, 2, 7, 31, 62, 63, 0};

    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1'b0, d); chk(d == 8'h3F, "R1 cmp reset", d, 8'h3F);
    rd(1'b1, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
    chk(resetReq == 1'b0 && irqFlag == 1'b0, "R1 outputs", {resetReq, irqFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    rd(1'b0, d); chk(d == 8'h3F, "R1 cmp after release", d, 8'h3F);

    // R3 readback: bit6 and bit7 read 0
    wr(1'b0, 8'hFA);
    rd(1'b0, d); chk(d == 8'h3A, "R3 cmp readback", d, 8'h3A);
    // R4 readback of enable
    wr(1'b1, 8'h20);
    rd(1'b1, d); chk(d == 8'h20, "R4 ctrl readback", d, 8'h20);
    wr(1'b1, 8'h00);
    rd(1'b1, d); chk(d == 8'h00, "R4 ctrl disable", d, 0);

    // R6 sweep: every match value, two back-to-back periods each
    for (int m = 0; m < 64; m++) begin
      wr(1'b0, 8'(m) | 8'h40);
      wr(1'b1, 8'h80);
      pulsesBefore = rstRises;
      for (int p = 0; p < 2; p++) begin
        n = 0;
        while (!irqFlag && n < 70) begin pulseTick(); n++; end
        chk(n == ((m == 0) ? 64 : m), "R6 interval", n, (m == 0) ? 64 : m);
        rd(1'b1, d); chk(d == 8'h80, "R4 irq readback", d, 8'h80);
        wr(1'b1, 8'h80);
      end
      chk(rstRises == pulsesBefore, "R6 no reset request", rstRises, pulsesBefore);
    end

    // R7 write with bit7=0 keeps the flag; bit7=1 clears it
    wr(1'b0, 8'h42);
    pulseTick(); pulseTick();
    wr(1'b1, 8'h00);
    chk(irqFlag == 1'b1, "R7 no clear without bit7", irqFlag, 1);
    wr(1'b1, 8'h80);
    chk(irqFlag == 1'b0, "R7 clear", irqFlag, 0);

    // R7 set and clear on one edge: set wins (match value 1)
    wr(1'b0, 8'h41);
    pulseTick();
    chk(irqFlag == 1'b1, "R7 setup", irqFlag, 1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    regWrEn = 1'b1; regSel = 1'b1; regWrData = 8'h80;
    @(negedge clk); regWrEn = 1'b0; regSel = 1'b0;
    chk(irqFlag == 1'b1, "R7 set beats clear", irqFlag, 1);
    wr(1'b1, 8'h80);

    // R8 clear write coincident with a tick: tick discarded
    wr(1'b0, 8'h43);
    pulseTick(); pulseTick();
    @(negedge clk); tick = 1'b1; regWrEn = 1'b1; regSel = 1'b0; regWrData = 8'h43;
    @(negedge clk); tick = 1'b0; regWrEn = 1'b0;
    pulseTick(); pulseTick();
    chk(irqFlag == 1'b0, "R8 tick dropped", irqFlag, 0);
    pulseTick();
    chk(irqFlag == 1'b1, "R8 full interval", irqFlag, 1);
    wr(1'b1, 8'h80);

    // R2 stop freezes the count, resumes afterwards
    wr(1'b0, 8'h45);
    repeat (4) pulseTick();
    stopMode = 1'b1;
    repeat (10) pulseTick();
    chk(irqFlag == 1'b0, "R2 stop holds", irqFlag, 0);
    stopMode = 1'b0;
    pulseTick();
    chk(irqFlag == 1'b1, "R2 resume", irqFlag, 1);
    wr(1'b1, 8'h80);

    // R5 watchdog sweep
    wr(1'b1, 8'h20);
    foreach (mList[i]) begin
      wr(1'b0, 8'(mList[i]) | 8'h40);
      base = rstRises;
      highBefore = rstHigh;
      n = 0;
      while (rstRises == base && n < 70) begin pulseTick(); n++; end
      chk(n == ((mList[i] == 0) ? 64 : mList[i]), "R5 detection ticks", n,
          (mList[i] == 0) ? 64 : mList[i]);
      chk(rstHigh - highBefore == 1, "R5 pulse width", rstHigh - highBefore, 1);
      chk(irqFlag == 1'b0, "R5 no irq", irqFlag, 0);
    end

    // R5 periodic clearing prevents a reset
    wr(1'b0, 8'h4A);
    base = rstRises;
    repeat (9) pulseTick();
    wr(1'b0, 8'h4A);
    repeat (9) pulseTick();
    chk(rstRises == base, "R5 serviced no reset", rstRises, base);
    pulseTick();
    chk(rstRises == base + 1, "R5 unserviced reset", rstRises, base + 1);

    // R1 system reset returns enable and counter to defaults
    wr(1'b0, 8'h05);
    pulseTick(); pulseTick();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(1'b1, d); chk(d == 8'h00, "R1 enable cleared by reset", d, 0);
    wr(1'b0, 8'h01);
    pulseTick();
    chk(irqFlag == 1'b1, "R1 counter cleared by reset", irqFlag, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule